// File: doc/BRIEF.md
# PCI INTx Interrupt Router

This block steers four shared PCI interrupt request lines onto the inputs of a legacy sixteen-input interrupt controller. Each request line owns a one-byte steering register. Software writes these registers through a byte-enabled configuration write port. A steering value below the number of controller inputs names the input that the line drives. Any larger value leaves the line unrouted. Several lines may share one input, and that input is then the OR of their levels.

Internally the block keeps a level map with one bit per (controller input, request line) pair, at bit index input × 4 + line. A small state machine has two states. In TRACK, it copies each routed line's level into that line's single map bit on every clock. A write that lands on any steering byte moves it to REBUILD for one cycle. In REBUILD, it clears the whole map and refills it from the current line levels under the new steering values. It then returns to TRACK. Each controller output is the OR of its four-bit group of the registered map.

A combinational query port takes a device number and an INTx pin. It returns the request line that the pin is swizzled onto, and whether that line is routed and to which input.

Top module: `intx_router`

## Requirements
- R1: After reset every steering register holds 0x80 (unrouted), a read of the steering dword returns 0x80808080, and all controller outputs are low.
- R2: A write with `cfg_dw_addr` = 0x18 stores byte lane k of `cfg_wdata` (bits 8k+7..8k) into the steering register of line k (A=0 … D=3) only where `cfg_be[k]` is set; writes to any other dword change no steering register; `cfg_rdata` returns `{D,C,B,A}` for dword 0x18 and zero otherwise.
- R3: A steering value of 16 or above (any of bits 7..4 set) leaves the line unrouted: its level changes affect no controller output.
- R4: For a routed line, `irq_out[steering value]` follows the line level sampled at a clock edge, visible right after that edge.
- R5: Lines routed to the same input are ORed onto it; the input falls only when all of them are low.
- R6: A steering write accepted at edge E0 causes the state to go from TRACK to REBUILD. After E0 the outputs still reflect the old routing. At edge E1 the map is cleared and rebuilt from the current levels under the new routing, and the state returns to TRACK, so an input no longer routed falls and the new input follows the current level.
- R7: `q_pirq` = (`q_pin` + `q_dev` − 1) mod 4, where `q_dev` is the device number modulo 4.
- R8: `q_enabled` is 1 and `q_irq` gives the input number when line `q_pirq` is routed; otherwise `q_enabled` is 0 and `q_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address (byte address / 4) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data, byte lane k at bits 8k+7..8k |
| cfg_rdata | output | 32 | Read data for `cfg_dw_addr` |
| pirq_level | input | 4 | Levels of request lines A..D |
| irq_out | output | 16 | Controller input levels |
| q_dev | input | 2 | Device number modulo 4 for the swizzle query |
| q_pin | input | 2 | INTx pin (0=A .. 3=D) |
| q_pirq | output | 2 | Request line the pin maps to |
| q_enabled | output | 1 | That line is routed |
| q_irq | output | 4 | Controller input of that line, 0 when unrouted |

## Verification
The assertions assume that the request levels and configuration inputs are steady around each rising edge. They also assume that a steering write is a single-cycle strobe, so each accepted write is followed by one REBUILD cycle before the next one. The bench drives every input on the falling edge and raises `cfg_we` for exactly one cycle per write. It changes line levels only between writes, so the count of lit outputs never exceeds the count of lines that were high at the previous edge.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
    localparam int NUM_PIRQ   = 4;
    localparam int NUM_INPUTS = 16;
    localparam int IN_W       = $clog2(NUM_INPUTS);
    localparam int P_W        = $clog2(NUM_PIRQ);
    localparam int MAP_W      = NUM_INPUTS * NUM_PIRQ;
    localparam logic [5:0] ROUTE_DW    = 6'h18;
    localparam logic [7:0] ROUTE_RESET = 8'h80;

    typedef logic [7:0] steer_t;

    typedef enum logic {
        ST_TRACK   = 1'b0,
        ST_REBUILD = 1'b1
    } map_state_e;

    function automatic logic steer_ok(input steer_t v);
        return v < 8'(NUM_INPUTS);
    endfunction
endpackage

// File: rtl/intx_steer_regs.sv
module intx_steer_regs
    import intx_router_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [5:0]                         dw_addr_i,
    input  logic [NUM_PIRQ-1:0]                be_i,
    input  logic [8*NUM_PIRQ-1:0]              wdata_i,
    output logic [8*NUM_PIRQ-1:0]              rdata_o,
    output steer_t [NUM_PIRQ-1:0]              steer_o,
    output logic                               hit_o
);
    steer_t [NUM_PIRQ-1:0] steer_q;
    logic dw_match;

    assign dw_match = (dw_addr_i == ROUTE_DW);
    assign hit_o    = we_i && dw_match && (|be_i);
    assign steer_o  = steer_q;
    assign rdata_o  = dw_match ? steer_q : '0;

    for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                steer_q[k] <= ROUTE_RESET;
            else if (hit_o && be_i[k])
                steer_q[k] <= wdata_i[8*k +: 8];
        end

        p_lane_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o && be_i[k]) |=> (steer_o[k] == $past(wdata_i[8*k +: 8])));
        p_lane_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            !(hit_o && be_i[k]) |=> $stable(steer_o[k]));
    end
endmodule

// File: rtl/intx_level_map.sv
module intx_level_map
    import intx_router_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit_i,
    input  steer_t [NUM_PIRQ-1:0] steer_i,
    input  logic [NUM_PIRQ-1:0]   lvl_i,
    output logic [NUM_INPUTS-1:0] irq_o
);
    map_state_e state_q, state_nx;
    logic [MAP_W-1:0] map_q, map_nx, legal_mask;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_TRACK:   if (hit_i) state_nx = ST_REBUILD;
            ST_REBUILD: state_nx = hit_i ? ST_REBUILD : ST_TRACK;
        endcase
    end

    // level map: incremental in TRACK, cleared and refilled in REBUILD
    always_comb begin
        unique case (state_q)
            ST_TRACK:   map_nx = map_q;
            ST_REBUILD: map_nx = '0;
        endcase
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (steer_ok(steer_i[p]))
                map_nx[int'(steer_i[p][IN_W-1:0]) * NUM_PIRQ + p] = lvl_i[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_nx;
    end

    // outputs: one OR per controller input group
    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_out
        assign irq_o[i] = |map_q[i*NUM_PIRQ +: NUM_PIRQ];
    end

    // positions the current routing allows (checker only)
    always_comb begin
        legal_mask = '0;
        for (int p = 0; p < NUM_PIRQ; p++)
            if (steer_ok(steer_i[p]))
                legal_mask[int'(steer_i[p][IN_W-1:0]) * NUM_PIRQ + p] = 1'b1;
    end

    p_enter_rebuild_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (state_q == ST_REBUILD));
    p_leave_rebuild_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REBUILD && !hit_i) |=> (state_q == ST_TRACK));
    p_no_stray_bit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |-> ((map_q & ~legal_mask) == '0));
    p_out_bounded_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ($countones(irq_o) <= $countones($past(lvl_i))));
endmodule

// File: rtl/intx_swizzle.sv
module intx_swizzle
    import intx_router_pkg::*;
(
    input  steer_t [NUM_PIRQ-1:0] steer_i,
    input  logic [P_W-1:0]        dev_i,
    input  logic [P_W-1:0]        pin_i,
    output logic [P_W-1:0]        pirq_o,
    output logic                  en_o,
    output logic [IN_W-1:0]       irq_o
);
    steer_t sel;

    assign pirq_o = pin_i + dev_i - P_W'(1);
    assign sel    = steer_i[pirq_o];
    assign en_o   = steer_ok(sel);
    assign irq_o  = en_o ? sel[IN_W-1:0] : '0;

    always_comb begin
        a_query_r8 : assert (en_o || irq_o == '0);
    end
endmodule

// File: rtl/intx_router.sv
module intx_router
    import intx_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [3:0]  pirq_level,
    output logic [15:0] irq_out,
    input  logic [1:0]  q_dev,
    input  logic [1:0]  q_pin,
    output logic [1:0]  q_pirq,
    output logic        q_enabled,
    output logic [3:0]  q_irq
);
    steer_t [NUM_PIRQ-1:0] steer;
    logic wr_hit;

    intx_steer_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .dw_addr_i(cfg_dw_addr),
        .be_i(cfg_be), .wdata_i(cfg_wdata), .rdata_o(cfg_rdata),
        .steer_o(steer), .hit_o(wr_hit)
    );

    intx_level_map u_map (
        .clk(clk), .rst_n(rst_n), .hit_i(wr_hit), .steer_i(steer),
        .lvl_i(pirq_level), .irq_o(irq_out)
    );

    intx_swizzle u_swz (
        .steer_i(steer), .dev_i(q_dev), .pin_i(q_pin),
        .pirq_o(q_pirq), .en_o(q_enabled), .irq_o(q_irq)
    );

    p_reset_quiet_r1 : assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/sim_intx_router.sv
module sim_intx_router;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [5:0]  cfg_dw_addr = 0;
    logic [3:0]  cfg_be = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pirq_level = 0;
    logic [15:0] irq_out;
    logic [1:0]  q_dev = 0, q_pin = 0, q_pirq;
    logic        q_enabled;
    logic [3:0]  q_irq;

    int checks = 0, errors = 0;
    logic [7:0] exp_rt [4];

    always #5 clk = ~clk;

    intx_router u0 (.*);

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] model_irq();
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (exp_rt[p] < 8'd16 && pirq_level[p]) r[exp_rt[p][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    // drives one write strobe; returns at the falling edge after acceptance
    task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        cfg_we = 1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
        if (a == 6'h18)
            for (int k = 0; k < 4; k++) if (be[k]) exp_rt[k] = d[8*k +: 8];
    endtask

    task automatic set_lvl(logic [3:0] l);
        pirq_level = l; cyc();
    endtask

    task automatic t_reset();
        cfg_dw_addr = 6'h18; #1;
        check("R1 rdata", cfg_rdata, 32'h80808080);
        check("R1 irq", {16'h0, irq_out}, 32'h0);
        set_lvl(4'hF);
        check("R1 unrouted lines", {16'h0, irq_out}, 32'h0);
        set_lvl(4'h0);
    endtask

    task automatic t_cfg_write();
        wr(6'h18, 4'b0101, 32'h11_03_22_05); cyc();
        cfg_dw_addr = 6'h18; #1;
        check("R2 partial be", cfg_rdata, 32'h80038005);
        wr(6'h19, 4'hF, 32'h01010101); cyc();
        cfg_dw_addr = 6'h18; #1;
        check("R2 other dword", cfg_rdata, 32'h80038005);
        cfg_dw_addr = 6'h17; #1;
        check("R2 read other", cfg_rdata, 32'h0);
    endtask

    task automatic t_single_route();
        wr(6'h18, 4'hF, 32'h80808007); cyc();
        set_lvl(4'b0001);
        check("R4 rise", {16'h0, irq_out}, 32'h0080);
        set_lvl(4'b0000);
        check("R4 fall", {16'h0, irq_out}, 32'h0);
    endtask

    task automatic t_disabled();
        wr(6'h18, 4'hF, 32'hFF_90_10_02); cyc();
        set_lvl(4'b1110);
        check("R3 disabled lines", {16'h0, irq_out}, 32'h0);
        set_lvl(4'b1111);
        check("R3 only routed", {16'h0, irq_out}, 32'h0004);
        set_lvl(4'b0000);
    endtask

    task automatic t_share();
        wr(6'h18, 4'hF, 32'h0B_0B_0B_0A); cyc();
        set_lvl(4'b0110);
        check("R5 or two", {16'h0, irq_out}, 32'h0800);
        set_lvl(4'b0100);
        check("R5 one left", {16'h0, irq_out}, 32'h0800);
        set_lvl(4'b1001);
        check("R5 mix", {16'h0, irq_out}, 32'h0C00);
        set_lvl(4'b0000);
        check("R5 all low", {16'h0, irq_out}, 32'h0);
    endtask

    task automatic t_reroute();
        logic [15:0] old_exp;
        wr(6'h18, 4'hF, 32'h80808003); cyc();
        set_lvl(4'b0001);
        check("R6 before", {16'h0, irq_out}, 32'h0008);
        old_exp = model_irq();
        wr(6'h18, 4'b0001, 32'h0000000E);
        check("R6 old routing held", {16'h0, irq_out}, {16'h0, old_exp});
        cyc();
        check("R6 rebuilt", {16'h0, irq_out}, {16'h0, model_irq()});
        check("R6 rebuilt value", {16'h0, irq_out}, 32'h4000);
        wr(6'h18, 4'b0001, 32'h000000FF); cyc();
        check("R6 disabled drops", {16'h0, irq_out}, 32'h0);
        set_lvl(4'b0000);
    endtask

    task automatic t_swizzle();
        for (int d = 0; d < 4; d++)
            for (int p = 0; p < 4; p++) begin
                q_dev = 2'(d); q_pin = 2'(p); #1;
                check("R7 swizzle", {30'h0, q_pirq}, 32'((p + d + 3) % 4));
            end
    endtask

    task automatic t_query();
        wr(6'h18, 4'hF, 32'h20_0F_80_09); cyc();
        q_dev = 2'd1; q_pin = 2'd0; #1;
        check("R8 en A", {31'h0, q_enabled}, 32'h1);
        check("R8 irq A", {28'h0, q_irq}, 32'h9);
        q_pin = 2'd1; #1;
        check("R8 dis B", {27'h0, q_enabled, q_irq}, 32'h0);
        q_pin = 2'd2; #1;
        check("R8 irq C", {27'h0, q_enabled, q_irq}, 32'h1F);
        q_pin = 2'd3; #1;
        check("R8 dis D", {27'h0, q_enabled, q_irq}, 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) exp_rt[k] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cfg_write();
        t_single_route();
        t_disabled();
        t_share();
        t_reroute();
        t_swizzle();
        t_query();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog got=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule